// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus (SCL clock, SDA data, both open-drain). Through it a bus controller reads and writes a bank of eight 8-bit configuration registers that steer a clock generator: four output enables, the spread amount, spread on/off, the output frequency and two test controls. Both bus lines are oversampled by the system clock through synchronizers. START, repeated START and STOP are detected from the SDA transitions that occur while SCL is high. SDA is never driven high: the block only pulls it low through an enable output.

Every transaction begins with the address byte, followed by a command byte. Command bit 7 picks the transfer type. When it is 1 the transfer is an indexed single-byte access at the offset in bits 4:0. When it is 0 the transfer is a counted block access that always starts at register 0. A block write sends a byte count before its data. A block read first returns a count of 8 and then the registers in ascending order. Reads use a repeated START with the read form of the address. A STOP after any complete byte ends the transfer.

Top module: `cfg_twowire_slave`

## Requirements
- R1: Reset loads register 0 = 7Ch, register 2 = EBh, register 7 = 01h and all others 00h. Coming out of reset, every output enable is 1, spread select is 1, spread enable is 0, frequency select is 1, both test lines are 0, and SDA is not driven.
- R2: Only the 7-bit address 69h is acknowledged (bytes D2h for write, D3h for read). For any other address the ninth clock is left undriven and the rest of the transfer has no effect until the next START. The SDA drive changes only while SCL is low.
- R3: In a byte write (command bit 7 = 1, bits 6:5 = 00, bits 4:0 = offset), the single data byte, received MSB first, is stored at the offset and acknowledged.
- R4: A command whose bits 6:5 are not 00 is not acknowledged, and no register changes for the rest of that transfer.
- R5: In a block write (command bit 7 = 0), the byte after the command is a count N. The next N data bytes go to registers 0, 1, 2 and upward. Data bytes beyond N are acknowledged and discarded.
- R6: A byte read returns the register at the offset, MSB first. Offsets 8 to 31 return 00h.
- R7: A block read returns 08h, then registers 0 through 7 in ascending order. After the controller's NACK, SDA is released.
- R8: Register 7 is read-only. Writes to it, and writes to offsets 8 to 31, are acknowledged and have no effect.
- R9: The control outputs follow the registers. The output enable for output k (1..4) is register 0 bit k+2. Spread select is register 2 bit 7, spread enable is register 2 bit 2, frequency select is register 2 bit 0, test select is register 6 bit 7 and test mode is register 6 bit 6. These outputs change only when a register is written.
- R10: A STOP at any point returns the slave to idle with SDA released, and no register is written. While idle the slave never drives SDA. A START or repeated START always restarts the address phase.
- R11: In block access the offset bits of the command are ignored, and the transfer starts at register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| out_en_o | output | 4 | Output enables, bit k-1 for output k; 0 means high-Z |
| spread_sel_o | output | 1 | Spread amount select (1 = larger down-spread) |
| spread_en_o | output | 1 | Spread modulation on |
| freq_sel_o | output | 1 | Output frequency select (1 = high rate) |
| test_sel_o | output | 1 | Test clock source select |
| test_mode_o | output | 1 | Test mode entry |

## Verification
The bench drives the following corner cases and names the fault each one exposes:

- **Data bytes past the block count.** A slave that ignored the count would overwrite register 3, which a later read would show.
- **Block command with a nonzero offset field.** A slave that honoured the offset would put the data in register 5 and leave the output enables unchanged.
- **Writes to the read-only register and to offsets past the bank.** A slave that stored these would return FFh instead of 01h from register 7, or AAh instead of 00h from offset 12.
- **Wrong chip-select field and wrong address.** Each is followed by bytes that would change the spread and frequency outputs if the slave did not stay idle.
- **STOP right after a command byte.** A slave that did not return to idle would mis-handle the next write.
- **Full block read.** The read checks the leading count and the ascending order, and checks that SDA is released after the controller's NACK.

// File: rtl/cfg_tw_pkg.sv
package cfg_tw_pkg;

    localparam int DW      = 8;   // register and bus byte width
    localparam int NREGS   = 8;   // registers in the bank
    localparam int IDX_W   = 5;   // offset field width in the command
    localparam int RO_IDX  = 7;   // read-only identity register
    localparam int NUM_OUT = 4;   // output enables
    localparam int BIT_W   = $clog2(DW);

    // command byte layout
    localparam int CMD_BYTE_BIT = 7;
    localparam int CS_HI        = 6;
    localparam int CS_LO        = 5;

    // control bit locations
    localparam int OE_REG       = 0;
    localparam int OE_LSB       = 3;
    localparam int SS_REG       = 2;
    localparam int SS_SEL_BIT   = 7;
    localparam int SS_EN_BIT    = 2;
    localparam int FREQ_BIT     = 0;
    localparam int TST_REG      = 6;
    localparam int TST_SEL_BIT  = 7;
    localparam int TST_MODE_BIT = 6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_RXEND, ST_ACK, ST_TX, ST_MACK, ST_MACKD
    } tw_state_e;

    typedef enum logic [1:0] {
        PH_ADDR, PH_CMD, PH_COUNT, PH_DATA
    } tw_phase_e;

    typedef struct packed {
        tw_state_e          st;
        tw_phase_e          ph;
        logic [BIT_W-1:0]   bit_cnt;
        logic [DW-1:0]      shreg;
        logic [DW-1:0]      txsh;
        logic [IDX_W-1:0]   ptr;
        logic [DW-1:0]      remain;
        logic               cnt_pend;
        logic               go_tx;
        logic               oe;
    } tw_ctx_t;

    function automatic logic [DW-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h7C;
            2:       return 8'hEB;
            7:       return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfg_tw_line_sync.sv
module cfg_tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_ev_o,
    output logic stop_ev_o
);

    logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
    logic              scl_prev_q, sda_prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe_q <= '1;
                    sda_pipe_q <= '1;
                end else begin
                    scl_pipe_q <= scl_i;
                    sda_pipe_q <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe_q <= '1;
                    sda_pipe_q <= '1;
                end else begin
                    scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
                    sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_pipe_q[STAGES-1];
            sda_prev_q <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_s_o    = scl_pipe_q[STAGES-1];
    assign sda_s_o    = sda_pipe_q[STAGES-1];
    assign scl_rise_o = scl_s_o & ~scl_prev_q;
    assign scl_fall_o = ~scl_s_o & scl_prev_q;
    assign start_ev_o = scl_s_o & scl_prev_q & sda_prev_q & ~sda_s_o;
    assign stop_ev_o  = scl_s_o & scl_prev_q & ~sda_prev_q & sda_s_o;

endmodule

// File: rtl/cfg_tw_reg_bank.sv
module cfg_tw_reg_bank
    import cfg_tw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [DW-1:0]      wr_data_i,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic [DW-1:0]      rd_data_o,
    output logic [NUM_OUT-1:0] out_en_o,
    output logic               spread_sel_o,
    output logic               spread_en_o,
    output logic               freq_sel_o,
    output logic               test_sel_o,
    output logic               test_mode_o
);

    localparam int                 AW      = $clog2(NREGS);
    localparam logic [IDX_W-1:0]   NREGS_I = IDX_W'(NREGS);

    logic [NREGS-1:0][DW-1:0] regs_q;

    generate
        for (genvar i = 0; i < NREGS; i++) begin : g_reg
            localparam logic [DW-1:0] RST = reg_default(i);
            if (i == RO_IDX) begin : g_ro
                assign regs_q[i] = RST;
            end else begin : g_rw
                logic [DW-1:0] cell_d, cell_q;
                always_comb begin
                    cell_d = cell_q;
                    if (wr_en_i && (wr_idx_i == IDX_W'(i)))
                        cell_d = wr_data_i;
                end
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) cell_q <= RST;
                    else        cell_q <= cell_d;
                end
                assign regs_q[i] = cell_q;
            end
        end
    endgenerate

    assign rd_data_o    = (rd_idx_i < NREGS_I) ? regs_q[rd_idx_i[AW-1:0]] : '0;

    assign out_en_o     = regs_q[OE_REG][OE_LSB +: NUM_OUT];
    assign spread_sel_o = regs_q[SS_REG][SS_SEL_BIT];
    assign spread_en_o  = regs_q[SS_REG][SS_EN_BIT];
    assign freq_sel_o   = regs_q[SS_REG][FREQ_BIT];
    assign test_sel_o   = regs_q[TST_REG][TST_SEL_BIT];
    assign test_mode_o  = regs_q[TST_REG][TST_MODE_BIT];

endmodule

// File: rtl/cfg_tw_proto_fsm.sv
module cfg_tw_proto_fsm
    import cfg_tw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             sda_s_i,
    input  logic             start_ev_i,
    input  logic             stop_ev_i,
    input  logic [DW-1:0]    rd_data_i,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [DW-1:0]    wr_data_o,
    output logic             sda_oe_o,
    output logic             busy_o
);

    localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(DW - 1);
    localparam logic [DW-1:0]    COUNT_BYTE = DW'(NREGS);

    tw_ctx_t q, d;
    logic [DW-1:0] nxt_byte;

    function automatic logic [IDX_W-1:0] sat_inc(input logic [IDX_W-1:0] p);
        return (&p) ? p : p + IDX_W'(1);
    endfunction

    always_comb begin
        d        = q;
        wr_en_o  = 1'b0;
        nxt_byte = q.cnt_pend ? COUNT_BYTE : rd_data_i;

        if (start_ev_i) begin
            d.st      = ST_RX;
            d.ph      = PH_ADDR;
            d.bit_cnt = '0;
            d.oe      = 1'b0;
        end else if (stop_ev_i) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_IDLE: ;
                ST_RX: begin
                    if (scl_rise_i) begin
                        d.shreg = {q.shreg[DW-2:0], sda_s_i};
                        if (q.bit_cnt == LAST_BIT) d.st = ST_RXEND;
                        else                       d.bit_cnt = q.bit_cnt + BIT_W'(1);
                    end
                end
                ST_RXEND: begin
                    if (scl_fall_i) begin
                        d.bit_cnt = '0;
                        d.st      = ST_ACK;
                        d.oe      = 1'b1;
                        d.go_tx   = 1'b0;
                        unique case (q.ph)
                            PH_ADDR: begin
                                if (q.shreg[DW-1:1] == DEV_ADDR) begin
                                    d.go_tx = q.shreg[0];
                                    if (!q.shreg[0]) d.ph = PH_CMD;
                                end else begin
                                    d.st = ST_IDLE;
                                    d.oe = 1'b0;
                                end
                            end
                            PH_CMD: begin
                                if (q.shreg[CS_HI:CS_LO] != 2'b00) begin
                                    d.st = ST_IDLE;
                                    d.oe = 1'b0;
                                end else if (q.shreg[CMD_BYTE_BIT]) begin
                                    d.ptr      = q.shreg[IDX_W-1:0];
                                    d.remain   = DW'(1);
                                    d.cnt_pend = 1'b0;
                                    d.ph       = PH_DATA;
                                end else begin
                                    d.ptr      = '0;
                                    d.cnt_pend = 1'b1;
                                    d.ph       = PH_COUNT;
                                end
                            end
                            PH_COUNT: begin
                                d.remain = q.shreg;
                                d.ph     = PH_DATA;
                            end
                            PH_DATA: begin
                                if (q.remain != '0) begin
                                    wr_en_o  = 1'b1;
                                    d.remain = q.remain - DW'(1);
                                    d.ptr    = sat_inc(q.ptr);
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        if (q.go_tx) begin
                            d.st      = ST_TX;
                            d.bit_cnt = '0;
                            d.txsh    = nxt_byte;
                            d.oe      = ~nxt_byte[DW-1];
                            if (q.cnt_pend) d.cnt_pend = 1'b0;
                            else            d.ptr = sat_inc(q.ptr);
                        end else begin
                            d.st = ST_RX;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall_i) begin
                        if (q.bit_cnt == LAST_BIT) begin
                            d.st = ST_MACK;
                            d.oe = 1'b0;
                        end else begin
                            d.txsh    = q.txsh << 1;
                            d.oe      = ~q.txsh[DW-2];
                            d.bit_cnt = q.bit_cnt + BIT_W'(1);
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise_i) d.st = sda_s_i ? ST_IDLE : ST_MACKD;
                end
                ST_MACKD: begin
                    if (scl_fall_i) begin
                        d.st      = ST_TX;
                        d.bit_cnt = '0;
                        d.txsh    = nxt_byte;
                        d.oe      = ~nxt_byte[DW-1];
                        if (q.cnt_pend) d.cnt_pend = 1'b0;
                        else            d.ptr = sat_inc(q.ptr);
                    end
                end
                default: begin
                    d.st = ST_IDLE;
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_idx_o  = q.ptr;
    assign wr_idx_o  = q.ptr;
    assign wr_data_o = q.shreg;
    assign sda_oe_o  = q.oe;
    assign busy_o    = (q.st != ST_IDLE);

endmodule

// File: rtl/cfg_twowire_slave.sv
module cfg_twowire_slave
    import cfg_tw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    output logic [NUM_OUT-1:0] out_en_o,
    output logic               spread_sel_o,
    output logic               spread_en_o,
    output logic               freq_sel_o,
    output logic               test_sel_o,
    output logic               test_mode_o
);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic wr_en, busy;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [DW-1:0]    wr_data, rd_data;

    cfg_tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_s_o    (scl_s),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_ev_o (start_ev),
        .stop_ev_o  (stop_ev)
    );

    cfg_tw_proto_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .sda_s_i    (sda_s),
        .start_ev_i (start_ev),
        .stop_ev_i  (stop_ev),
        .rd_data_i  (rd_data),
        .rd_idx_o   (rd_idx),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data),
        .sda_oe_o   (sda_oe_o),
        .busy_o     (busy)
    );

    cfg_tw_reg_bank u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .wr_idx_i     (wr_idx),
        .wr_data_i    (wr_data),
        .rd_idx_i     (rd_idx),
        .rd_data_o    (rd_data),
        .out_en_o     (out_en_o),
        .spread_sel_o (spread_sel_o),
        .spread_en_o  (spread_en_o),
        .freq_sel_o   (freq_sel_o),
        .test_sel_o   (test_sel_o),
        .test_mode_o  (test_mode_o)
    );

endmodule

// File: rtl/cfg_twowire_slave_chk.sv
module cfg_twowire_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       stop_ev,
    input logic       busy,
    input logic       wr_en,
    input logic       sda_oe,
    input logic [8:0] ctrl
);

    // R10: no drive on SDA while the protocol engine is idle
    p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sda_oe);

    // R10: a STOP releases SDA on the next cycle
    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    // R2: the SDA drive moves only while the synchronized SCL was low
    p_oe_moves_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R3: register writes happen in the SCL low phase
    p_wr_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !scl_s);

    // R9: control outputs hold unless a write was issued
    p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl));

endmodule

bind cfg_twowire_slave cfg_twowire_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .stop_ev (stop_ev),
    .busy    (busy),
    .wr_en   (wr_en),
    .sda_oe  (sda_oe_o),
    .ctrl    ({out_en_o, spread_sel_o, spread_en_o, freq_sel_o, test_sel_o, test_mode_o})
);

// File: tb/cfg_twowire_slave_tb_top.sv
module cfg_twowire_slave_tb_top;

    localparam int Q  = 10;       // clocks per quarter bus bit
    localparam int WD = 150000;   // watchdog limit in clocks

    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [3:0] out_en;
    logic       spread_sel, spread_en, freq_sel, test_sel, test_mode;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    exp_item_t  exp_q[$];
    logic [7:0] obs_q[$];

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    cfg_twowire_slave dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_oe_o     (sda_oe),
        .out_en_o     (out_en),
        .spread_sel_o (spread_sel),
        .spread_en_o  (spread_en),
        .freq_sel_o   (freq_sel),
        .test_sel_o   (test_sel),
        .test_mode_o  (test_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // {out_en[3:0], spread_sel, spread_en, freq_sel, test_sel, test_mode}
    task automatic ctrl_chk(input string tag, input logic [8:0] exp);
        chk(tag, {23'b0, out_en, spread_sel, spread_en, freq_sel, test_sel, test_mode}, {23'b0, exp});
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    // send a byte; exp_lvl is the expected SDA level in the ninth clock (0 = ACK)
    task automatic wbyte(input logic [7:0] b, input logic exp_lvl, input string tag);
        logic lvl;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        lvl = sda_bus;
        tick(Q);
        scl_m = 1'b0; tick(Q);
        chk(tag, {31'b0, lvl}, {31'b0, exp_lvl});
    endtask

    task automatic rbyte(input logic nack);
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q);
            v[i] = sda_bus;
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = nack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
        obs_q.push_back(v);
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_item_t e;
        e.v   = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr_txn(input logic [4:0] off, input logic [7:0] data, input string tag);
        bus_start();
        wbyte(8'hD2, 1'b0, tag);
        wbyte({3'b100, off}, 1'b0, tag);
        wbyte(data, 1'b0, tag);
        bus_stop();
    endtask

    task automatic rd_txn(input logic [4:0] off, input logic [7:0] exp, input string tag);
        bus_start();
        wbyte(8'hD2, 1'b0, tag);
        wbyte({3'b100, off}, 1'b0, tag);
        bus_start();
        wbyte(8'hD3, 1'b0, tag);
        expect_byte(exp, tag);
        rbyte(1'b1);
        bus_stop();
    endtask

    // monitor: pops observed read bytes and compares with the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            if (obs_q.size() > 0) begin
                logic [7:0] o;
                o = obs_q.pop_front();
                if (exp_q.size() == 0) begin
                    chk("R7 unexpected read byte", {24'b0, o}, 32'hFFFF_FFFF);
                end else begin
                    exp_item_t e;
                    e = exp_q.pop_front();
                    chk(e.tag, {24'b0, o}, {24'b0, e.v});
                end
            end
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 reset state
        ctrl_chk("R1 reset controls", 9'b1111_1_0_1_0_0);
        chk("R1 reset sda release", {31'b0, sda_oe}, 32'd0);

        // R2 foreign address, then bytes that would touch register 2
        bus_start();
        wbyte(8'hA0, 1'b1, "R2 foreign address not acked");
        wbyte(8'h82, 1'b1, "R2 ignored command");
        wbyte(8'h00, 1'b1, "R2 ignored data");
        bus_stop();
        ctrl_chk("R2 no effect after foreign address", 9'b1111_1_0_1_0_0);

        // R3 byte write register 2 = 05h
        wr_txn(5'd2, 8'h05, "R3 byte write ack");
        ctrl_chk("R3 R9 register 2 controls", 9'b1111_0_1_1_0_0);

        // R4 nonzero chip select
        bus_start();
        wbyte(8'hD2, 1'b0, "R4 address ack");
        wbyte(8'hA2, 1'b1, "R4 bad chip select nacked");
        wbyte(8'h80, 1'b1, "R4 data after nack ignored");
        bus_stop();
        ctrl_chk("R4 register 2 unchanged", 9'b1111_0_1_1_0_0);

        // R6 byte reads
        rd_txn(5'd2, 8'h05, "R6 read register 2");
        rd_txn(5'd9, 8'h00, "R6 read offset 9 zero");

        // R8 read-only and out-of-range writes
        rd_txn(5'd7, 8'h01, "R8 read identity register");
        wr_txn(5'd7, 8'hFF, "R8 write to read-only acked");
        rd_txn(5'd7, 8'h01, "R8 identity unchanged");
        wr_txn(5'd12, 8'hAA, "R8 write offset 12 acked");
        rd_txn(5'd12, 8'h00, "R8 offset 12 reads zero");

        // R5 block write with count 3 and one surplus byte
        bus_start();
        wbyte(8'hD2, 1'b0, "R5 address ack");
        wbyte(8'h00, 1'b0, "R5 block command ack");
        wbyte(8'h03, 1'b0, "R5 count ack");
        wbyte(8'h08, 1'b0, "R5 data0 ack");
        wbyte(8'h11, 1'b0, "R5 data1 ack");
        wbyte(8'hC4, 1'b0, "R5 data2 ack");
        wbyte(8'h5A, 1'b0, "R5 surplus data acked");
        bus_stop();
        ctrl_chk("R5 R9 block write controls", 9'b0001_1_1_0_0_0);
        rd_txn(5'd3, 8'h00, "R5 surplus byte discarded");
        rd_txn(5'd1, 8'h11, "R5 register 1 written");

        // R11 block command with offset bits set
        bus_start();
        wbyte(8'hD2, 1'b0, "R11 address ack");
        wbyte(8'h05, 1'b0, "R11 block command ack");
        wbyte(8'h01, 1'b0, "R11 count ack");
        wbyte(8'h78, 1'b0, "R11 data ack");
        bus_stop();
        ctrl_chk("R11 data landed in register 0", 9'b1111_1_1_0_0_0);
        rd_txn(5'd5, 8'h00, "R11 register 5 untouched");

        // R9 test controls
        wr_txn(5'd6, 8'hC0, "R9 write register 6");
        ctrl_chk("R9 test lines", 9'b1111_1_1_0_1_1);

        // R7 block read
        bus_start();
        wbyte(8'hD2, 1'b0, "R7 address ack");
        wbyte(8'h00, 1'b0, "R7 block command ack");
        bus_start();
        wbyte(8'hD3, 1'b0, "R7 read address ack");
        expect_byte(8'h08, "R7 count byte");
        expect_byte(8'h78, "R7 register 0");
        expect_byte(8'h11, "R7 register 1");
        expect_byte(8'hC4, "R7 register 2");
        expect_byte(8'h00, "R7 register 3");
        expect_byte(8'h00, "R7 register 4");
        expect_byte(8'h00, "R7 register 5");
        expect_byte(8'hC0, "R7 register 6");
        expect_byte(8'h01, "R7 register 7");
        for (int k = 0; k < 9; k++) rbyte(k == 8);
        tick(Q);
        chk("R7 sda released after nack", {31'b0, sda_oe}, 32'd0);
        bus_stop();

        // R10 STOP right after the command byte, then a clean transfer
        bus_start();
        wbyte(8'hD2, 1'b0, "R10 address ack");
        wbyte(8'h83, 1'b0, "R10 command ack");
        bus_stop();
        chk("R10 idle after stop", {31'b0, sda_oe}, 32'd0);
        rd_txn(5'd3, 8'h00, "R10 aborted write stored nothing");
        wr_txn(5'd3, 8'h3C, "R10 write after abort");
        rd_txn(5'd3, 8'h3C, "R10 read after abort");

        tick(4*Q);
        chk("R7 scoreboard drained", exp_q.size(), 32'd0);
        done = 1;
        summary();
        $finish;
    end

endmodule